// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter

This block lets two requesting ports share one memory interface. Each port asks for the memory by raising a level enable and drops that enable once its access is finished. The arbiter keeps one owner bit. Port 1 owns the memory by default. Port 2 takes it only when it asks and port 1 is either idle or has only just started asking. A port that holds the memory is never preempted.

The owner bit is registered and is also the `sel` output. It steers the address, write data, write strobe and enable of the owning port onto the memory bus. A registered copy of port 1's enable lets the block detect port 1's rising edge synchronously. That edge is what resolves a tie in favour of port 2.

Top module: `mem_share_arb`

## Requirements
- R1: While `rst` is high at a rising clock edge, the owner returns to port 1 (`sel` = 0) and the stored copy of `p1_en` is cleared to 0.
- R2: With `sel` = 0 the memory bus (`mem_en`, `mem_addr`, `mem_wdata`, `mem_we`) carries port 1's signals. With `sel` = 1 it carries port 2's signals.
- R3: If the owner is port 1, `p2_en` is high, and `p1_en` is high now but was low in the previous cycle, `sel` is 1 after the next edge. Port 2 wins a simultaneous start.
- R4: If the owner is port 1 and `p1_en` was already high in the previous cycle and is still high, `sel` stays 0 whatever `p2_en` does.
- R5: If the owner is port 1, `p1_en` is low and `p2_en` is high, `sel` is 1 after the next edge.
- R6: If the owner is port 2 and `p2_en` is high, `sel` stays 1 whatever `p1_en` does.
- R7: If the owner is port 2 and `p2_en` is low, `sel` is 0 after the next edge.
- R8: `grant1` is high exactly when `sel` = 0 and `p1_en` is high. `grant2` is high exactly when `sel` = 1. The two grants are never high together.
- R9: If the owner is port 1 and `p2_en` is low, `sel` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p1_en | input | 1 | Port 1 request level |
| p1_addr | input | ADDR_W | Port 1 address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_we | input | 1 | Port 1 write strobe |
| p2_en | input | 1 | Port 2 request level |
| p2_addr | input | ADDR_W | Port 2 address |
| p2_wdata | input | DATA_W | Port 2 write data |
| p2_we | input | 1 | Port 2 write strobe |
| sel | output | 1 | Registered owner: 0 port 1, 1 port 2 |
| grant1 | output | 1 | Port 1 is served |
| grant2 | output | 1 | Port 2 is served |
| mem_en | output | 1 | Enable of the owning port |
| mem_addr | output | ADDR_W | Address of the owning port |
| mem_wdata | output | DATA_W | Write data of the owning port |
| mem_we | output | 1 | Write strobe of the owning port |

## Verification
The assertions assume that both request enables are clean two-state values that are synchronous to `clk`. They also assume the enables never change close to a rising edge, so that the registered copy of `p1_en` matches the value seen in the previous cycle. The stimulus drives every input on the falling edge with two-state values only. It holds each enable for several cycles by toggling it with low probability, so long ownership periods and near-simultaneous starts both occur. Directed sequences add the exact tie, port 2 waiting behind a busy port 1, and a reset issued while port 2 owns the bus.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    OWN_P1 = 1'b0,
    OWN_P2 = 1'b1
  } owner_e;

  // synchronous rise: high now, low one clock ago
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // owner for the next cycle
  function automatic owner_e next_owner(input owner_e cur, input logic p1_en,
                                        input logic p1_rise, input logic p2_en);
    owner_e nxt;
    nxt = cur;
    case (cur)
      OWN_P1: if (p2_en && (!p1_en || p1_rise)) nxt = OWN_P2;
      OWN_P2: if (!p2_en) nxt = OWN_P1;
      default: nxt = OWN_P1;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/arb_p1_edge.sv
module arb_p1_edge
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic prev_o,
  output logic rise_o
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_i;
  end

  assign prev_o = en_q;
  assign rise_o = rise_of(en_i, en_q);

  // R1: the stored copy is cleared by reset
  assert_edge_clear_R1: assert property (@(posedge clk) rst |=> !prev_o);

  // R3: the copy follows the enable one cycle late
  assert_edge_track_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prev_o == $past(en_i));

endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic p1_en,
  input  logic p1_prev,
  input  logic p1_rise,
  input  logic p2_en,
  output logic sel_o,
  output logic grant1_o,
  output logic grant2_o
);

  owner_e owner_q;
  owner_e owner_d;

  always_comb owner_d = next_owner(owner_q, p1_en, p1_rise, p2_en);

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_P1;
    else     owner_q <= owner_d;
  end

  assign sel_o    = (owner_q == OWN_P2);
  assign grant1_o = (owner_q == OWN_P1) & p1_en;
  assign grant2_o = (owner_q == OWN_P2);

  assert_reset_owner_R1: assert property (@(posedge clk) rst |=> !sel_o);

  assert_tie_to_p2_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_o && p2_en && p1_en && !p1_prev) |=> sel_o);

  assert_hold_p1_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel_o && p1_en && p1_prev) |=> !sel_o);

  assert_idle_p1_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_o && !p1_en && p2_en) |=> sel_o);

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_o && p2_en) |=> sel_o);

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_o && !p2_en) |=> !sel_o);

  assert_grant_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(grant1_o && grant2_o));

  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!sel_o && !p2_en) |=> !sel_o);

endmodule

// File: rtl/arb_bus_route.sv
module arb_bus_route #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              sel_i,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_we,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_we,
  output logic              m_en,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_we
);

  localparam int BUS_W = ADDR_W + DATA_W + 2;

  logic [BUS_W-1:0] bus_a, bus_b, bus_m;

  assign bus_a = {a_en, a_we, a_addr, a_wdata};
  assign bus_b = {b_en, b_we, b_addr, b_wdata};
  assign bus_m = sel_i ? bus_b : bus_a;

  assign {m_en, m_we, m_addr, m_wdata} = bus_m;

endmodule

// File: rtl/mem_share_arb.sv
module mem_share_arb #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p1_en,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  input  logic              p1_we,
  input  logic              p2_en,
  input  logic [ADDR_W-1:0] p2_addr,
  input  logic [DATA_W-1:0] p2_wdata,
  input  logic              p2_we,
  output logic              sel,
  output logic              grant1,
  output logic              grant2,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  logic p1_prev_w;
  logic p1_rise_w;

  arb_p1_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .en_i   (p1_en),
    .prev_o (p1_prev_w),
    .rise_o (p1_rise_w)
  );

  arb_owner_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .p1_en    (p1_en),
    .p1_prev  (p1_prev_w),
    .p1_rise  (p1_rise_w),
    .p2_en    (p2_en),
    .sel_o    (sel),
    .grant1_o (grant1),
    .grant2_o (grant2)
  );

  arb_bus_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .sel_i   (sel),
    .a_en    (p1_en),
    .a_addr  (p1_addr),
    .a_wdata (p1_wdata),
    .a_we    (p1_we),
    .b_en    (p2_en),
    .b_addr  (p2_addr),
    .b_wdata (p2_wdata),
    .b_we    (p2_we),
    .m_en    (mem_en),
    .m_addr  (mem_addr),
    .m_wdata (mem_wdata),
    .m_we    (mem_we)
  );

  assert_route_p2_R2: assert property (@(posedge clk) disable iff (rst)
    sel |-> (mem_addr == p2_addr && mem_wdata == p2_wdata && mem_en == p2_en));

  assert_route_p1_R2: assert property (@(posedge clk) disable iff (rst)
    !sel |-> (mem_addr == p1_addr && mem_wdata == p1_wdata && mem_we == p1_we));

endmodule

// File: tb/sim_mem_share_arb.sv
`timescale 1ns/1ps
module sim_mem_share_arb;

  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic p1_en = 1'b0, p2_en = 1'b0, p1_we = 1'b0, p2_we = 1'b0;
  logic [AW-1:0] p1_addr = '0, p2_addr = '0;
  logic [DW-1:0] p1_wdata = '0, p2_wdata = '0;
  logic sel, grant1, grant2, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  logic m_own = 1'b0;
  logic m_p1d = 1'b0;

  always #4 clk = ~clk;

  mem_share_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .p1_en(p1_en), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_we(p1_we),
    .p2_en(p2_en), .p2_addr(p2_addr), .p2_wdata(p2_wdata), .p2_we(p2_we),
    .sel(sel), .grant1(grant1), .grant2(grant2),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  function automatic logic exp_owner(input logic own, input logic a, input logic ad,
                                     input logic b);
    if (own) return b;
    return b & ~(a & ad);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic b, input string req);
    rst      = r;
    p1_en    = a;
    p2_en    = b;
    p1_addr  = AW'($urandom);
    p2_addr  = AW'($urandom);
    p1_wdata = DW'($urandom);
    p2_wdata = DW'($urandom);
    p1_we    = 1'($urandom);
    p2_we    = 1'($urandom);
    @(posedge clk);
    if (r) begin m_own = 1'b0; m_p1d = 1'b0; end
    else begin m_own = exp_owner(m_own, a, m_p1d, b); m_p1d = a; end
    @(negedge clk);
    chk(req, {31'd0, sel}, {31'd0, m_own});
    chk("R8", {30'd0, grant1, grant2}, {30'd0, ~m_own & a, m_own});
    chk("R2", {14'd0, mem_en, mem_we, mem_addr},
        m_own ? {14'd0, p2_en, p2_we, p2_addr} : {14'd0, p1_en, p1_we, p1_addr});
    chk("R2", {16'd0, mem_wdata}, {16'd0, m_own ? p2_wdata : p1_wdata});
  endtask

  initial begin
    #1600000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic a, b;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(1, 1, 1, "R1");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R9");
    step(0, 1, 1, "R3");   // both start together: port 2 wins
    step(0, 1, 1, "R6");
    step(0, 1, 0, "R7");   // port 2 releases
    step(0, 1, 1, "R4");   // port 1 busy: port 2 waits
    step(0, 1, 1, "R4");
    step(0, 0, 1, "R5");   // port 1 released
    step(0, 1, 1, "R6");
    step(0, 0, 1, "R6");
    step(0, 0, 0, "R7");
    step(0, 0, 1, "R5");
    step(1, 0, 1, "R1");   // reset while port 2 owns
    step(0, 0, 0, "R9");
    step(0, 1, 0, "R9");
    a = 1'b0; b = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0) a = ~a;
      if ($urandom_range(3) == 0) b = ~b;
      step(($urandom_range(99) == 0), a, b, "R3");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule